// File: doc/BRIEF.md
# Pipeline Control Word Sequencer

This block is the control half of a five-stage in-order pipeline whose stages are fetch, decode/register read, execute, memory access and write-back. Each fetched instruction is latched, then decoded into one packed control word. The word holds execute controls, memory controls, a register-write flag, the destination register number and a valid bit. It then rides the execute, memory and write-back stage registers in step with the instruction. An external datapath reads the per-stage control outputs and needs no decoding of its own.

Every class that writes a register does so in stage 5 only. For register-register and logical-immediate results the memory stage simply passes the value along, so two instructions never meet at the single write port. The datapath reports two conditions during execute: whether the two branch operands are equal, and whether an arithmetic result overflowed. A taken branch redirects fetch. The one instruction after the branch (its delay slot) still completes. The instruction fetched in the following cycle is squashed by clearing its valid bit. An overflowing arithmetic instruction loses its register write before it reaches stage 5.

Top module: `pdc_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, every stage is empty. `id_valid_o`, `ex_valid_o`, `mem_read_o`, `mem_write_o`, `wb_we_o` and `redirect_o` are all 0. An instruction in flight when reset is asserted never writes.
- R2: A valid instruction captured at a clock edge is shown in decode during the next cycle. `id_rs_o` carries bits [25:21] and `id_rt_o` carries bits [20:16]. `id_valid_o` is 1 only for a recognised opcode. Opcode bits [31:26]: 0x00 register-register, 0x08 add-immediate, 0x0D or-immediate, 0x23 load, 0x2B store, 0x04 branch-if-equal. For register-register, the function code is bits [5:0]: 0x20 add, 0x22 sub, 0x24 and, 0x25 or.
- R3: One cycle after decode, the instruction is in execute with `ex_valid_o`=1. `ex_alu_op_o` is 0 for add, 1 for sub, 2 for and, 3 for or. Add-immediate, load and store use add with `ex_use_imm_o`=1. Or-immediate uses or with `ex_use_imm_o`=1 and `ex_zero_ext_o`=1. Branch uses sub with `ex_branch_o`=1.
- R4: In the memory stage, a load raises `mem_read_o` and a store raises `mem_write_o`. All other classes raise neither, so the stage passes the result through. The two strobes are never high together.
- R5: Every register-writing class raises `wb_we_o` exactly three cycles after its decode cycle, in stage 5 only. This holds for back-to-back mixes of loads and register-register operations. `wb_from_mem_o` is 1 only for loads.
- R6: Register-register instructions write to bits [15:11]. Add-immediate, or-immediate and load write to bits [20:16]. The number is shown on `wb_dest_o`.
- R7: Store and branch never raise `wb_we_o`, and branch raises no memory strobe. An unrecognised opcode, or a fetch with `fetch_valid_i` low, has no effect at any stage.
- R8: `redirect_o` is 1 in a cycle only when a valid branch is in execute and `ex_equal_i` is 1. `ex_equal_i` has no effect when execute holds anything else.
- R9: On a taken branch, the delay-slot instruction still completes normally. The instruction captured at the edge that ends the redirect cycle is squashed: it never shows in decode and never writes. When the branch is not taken, that instruction completes.
- R10: If `ex_ovf_i` is 1 while an add, sub or add-immediate is in execute, that instruction does not raise `wb_we_o`. `ex_ovf_i` has no effect on other classes or in other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | Fetched word is a real instruction |
| fetch_instr_i | input | 32 | Fetched instruction word |
| ex_equal_i | input | 1 | Branch operands equal, for the instruction in execute |
| ex_ovf_i | input | 1 | Arithmetic overflow, for the instruction in execute |
| id_rs_o | output | 5 | First register-read address |
| id_rt_o | output | 5 | Second register-read address |
| id_valid_o | output | 1 | Decode stage holds a live instruction |
| ex_valid_o | output | 1 | Execute stage holds a live instruction |
| ex_alu_op_o | output | 2 | ALU function select |
| ex_use_imm_o | output | 1 | Second ALU operand is the immediate |
| ex_zero_ext_o | output | 1 | Immediate is zero-extended rather than sign-extended |
| ex_branch_o | output | 1 | Execute holds a branch |
| redirect_o | output | 1 | Load the branch target into the fetch address |
| mem_read_o | output | 1 | Data memory read strobe |
| mem_write_o | output | 1 | Data memory write strobe |
| wb_we_o | output | 1 | Register file write enable |
| wb_dest_o | output | 5 | Register file write address |
| wb_from_mem_o | output | 1 | Write data comes from memory, not the passed result |

## Verification
The sharpest corner is the branch shadow. The bench checks that the delay slot still writes and that only the next instruction is dropped. A squash one cycle early would lose the delay slot, and a late one would let a wrong-path add write its register. Overflow is checked on the cycle of the flagged instruction alone. A design that samples the flag in the wrong stage would cancel a neighbour, or it would cancel or-immediate, which never overflows. Back-to-back loads and register-register operations check that each class writes in stage 5 with the right destination field. A design that writes register-register results a cycle early would show two writers colliding, or dropped destinations.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  localparam int INSTR_W = 32;
  localparam int RA_W    = 5;
  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int OP_LSB  = INSTR_W - OP_W;
  localparam int RS_LSB  = OP_LSB - RA_W;
  localparam int RT_LSB  = RS_LSB - RA_W;
  localparam int RD_LSB  = RT_LSB - RA_W;
  localparam int TAIL_N  = 2;   // memory and write-back stage registers

  localparam logic [OP_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LD   = 6'h23;
  localparam logic [OP_W-1:0] OPC_ST   = 6'h2B;

  localparam logic [FN_W-1:0] FNC_ADD = 6'h20;
  localparam logic [FN_W-1:0] FNC_SUB = 6'h22;
  localparam logic [FN_W-1:0] FNC_AND = 6'h24;
  localparam logic [FN_W-1:0] FNC_OR  = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu;
    logic    use_imm;
    logic    zero_ext;
    logic    is_branch;
    logic    ovf_chk;
  } ex_ctl_t;

  typedef struct packed {
    logic rd_en;
    logic wr_en;
  } me_ctl_t;

  typedef struct packed {
    logic reg_we;
    logic from_mem;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t         ex;
    me_ctl_t         me;
    wb_ctl_t         wb;
    logic [RA_W-1:0] dest;
    logic            vld;
  } ctl_word_t;

  function automatic logic [OP_W-1:0] f_opcode(input logic [INSTR_W-1:0] ir);
    return ir[OP_LSB +: OP_W];
  endfunction

  function automatic logic [RA_W-1:0] f_rs(input logic [INSTR_W-1:0] ir);
    return ir[RS_LSB +: RA_W];
  endfunction

  function automatic logic [RA_W-1:0] f_rt(input logic [INSTR_W-1:0] ir);
    return ir[RT_LSB +: RA_W];
  endfunction

  function automatic logic [RA_W-1:0] f_rd(input logic [INSTR_W-1:0] ir);
    return ir[RD_LSB +: RA_W];
  endfunction

  // Build the control word for one instruction; unknown encodings give an empty word.
  function automatic ctl_word_t f_decode(input logic [INSTR_W-1:0] ir, input logic live);
    ctl_word_t       w;
    logic            known;
    logic [FN_W-1:0] fn;
    w     = '0;
    known = 1'b1;
    fn    = ir[FN_W-1:0];
    case (f_opcode(ir))
      OPC_REG: begin
        w.wb.reg_we = 1'b1;
        w.dest      = f_rd(ir);
        case (fn)
          FNC_ADD: begin w.ex.alu = ALU_ADD; w.ex.ovf_chk = 1'b1; end
          FNC_SUB: begin w.ex.alu = ALU_SUB; w.ex.ovf_chk = 1'b1; end
          FNC_AND: w.ex.alu = ALU_AND;
          FNC_OR:  w.ex.alu = ALU_OR;
          default: known = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        w.ex.alu     = ALU_ADD;
        w.ex.use_imm = 1'b1;
        w.ex.ovf_chk = 1'b1;
        w.wb.reg_we  = 1'b1;
        w.dest       = f_rt(ir);
      end
      OPC_ORI: begin
        w.ex.alu      = ALU_OR;
        w.ex.use_imm  = 1'b1;
        w.ex.zero_ext = 1'b1;
        w.wb.reg_we   = 1'b1;
        w.dest        = f_rt(ir);
      end
      OPC_LD: begin
        w.ex.alu      = ALU_ADD;
        w.ex.use_imm  = 1'b1;
        w.me.rd_en    = 1'b1;
        w.wb.reg_we   = 1'b1;
        w.wb.from_mem = 1'b1;
        w.dest        = f_rt(ir);
      end
      OPC_ST: begin
        w.ex.alu     = ALU_ADD;
        w.ex.use_imm = 1'b1;
        w.me.wr_en   = 1'b1;
      end
      OPC_BEQ: begin
        w.ex.alu       = ALU_SUB;
        w.ex.is_branch = 1'b1;
      end
      default: known = 1'b0;
    endcase
    if (!(live && known)) w = '0;
    else                  w.vld = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/pdc_fetch_latch.sv
module pdc_fetch_latch
  import pdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               live_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               squash_i,
  output logic [INSTR_W-1:0] ir_o,
  output logic               live_o
);

  logic [INSTR_W-1:0] ir_q;
  logic               live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q   <= '0;
      live_q <= 1'b0;
    end else begin
      ir_q   <= instr_i;
      live_q <= live_i & ~squash_i;
    end
  end

  assign ir_o   = ir_q;
  assign live_o = live_q;

  a_r9_squash_drops_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> !live_o);

endmodule

// File: rtl/pdc_decode.sv
module pdc_decode
  import pdc_pkg::*;
(
  input  logic [INSTR_W-1:0] ir_i,
  input  logic               live_i,
  output ctl_word_t          word_o,
  output logic [RA_W-1:0]    rs_o,
  output logic [RA_W-1:0]    rt_o
);

  assign word_o = f_decode(ir_i, live_i);
  assign rs_o   = f_rs(ir_i);
  assign rt_o   = f_rt(ir_i);

endmodule

// File: rtl/pdc_ex_stage.sv
module pdc_ex_stage
  import pdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctl_word_t word_i,
  input  logic      equal_i,
  input  logic      ovf_i,
  output ex_ctl_t   ex_o,
  output logic      vld_o,
  output logic      redirect_o,
  output logic      ovf_kill_o,
  output ctl_word_t word_o
);

  ctl_word_t q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= word_i;
  end

  assign ex_o       = q.ex;
  assign vld_o      = q.vld;
  assign redirect_o = q.vld & q.ex.is_branch & equal_i;
  assign ovf_kill_o = q.vld & q.ex.ovf_chk & ovf_i;

  always_comb begin
    word_o = q;
    if (ovf_kill_o) word_o.wb.reg_we = 1'b0;
  end

  // R8: a redirect needs a live branch in this stage
  a_r8_redirect_from_branch: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (vld_o && ex_o.alu == ALU_SUB));

endmodule

// File: rtl/pdc_tail.sv
module pdc_tail
  import pdc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_word_t       word_i,
  output logic            mem_read_o,
  output logic            mem_write_o,
  output logic            mem_wb_pend_o,
  output logic            wb_we_o,
  output logic            wb_from_mem_o,
  output logic [RA_W-1:0] wb_dest_o
);

  ctl_word_t stg_q [TAIL_N];

  generate
    for (genvar g = 0; g < TAIL_N; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= word_i;
        end
      end else begin : g_follow
        always_ff @(posedge clk) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign mem_read_o    = stg_q[0].vld & stg_q[0].me.rd_en;
  assign mem_write_o   = stg_q[0].vld & stg_q[0].me.wr_en;
  assign mem_wb_pend_o = stg_q[0].vld & stg_q[0].wb.reg_we;
  assign wb_we_o       = stg_q[TAIL_N-1].vld & stg_q[TAIL_N-1].wb.reg_we;
  assign wb_from_mem_o = stg_q[TAIL_N-1].wb.from_mem;
  assign wb_dest_o     = stg_q[TAIL_N-1].dest;

  a_r4_one_mem_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read_o && mem_write_o));

  a_r7_store_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write_o |=> !wb_we_o);

endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid_i,
  input  logic [INSTR_W-1:0]   fetch_instr_i,
  input  logic                 ex_equal_i,
  input  logic                 ex_ovf_i,
  output logic [RA_W-1:0]      id_rs_o,
  output logic [RA_W-1:0]      id_rt_o,
  output logic                 id_valid_o,
  output logic                 ex_valid_o,
  output logic [1:0]           ex_alu_op_o,
  output logic                 ex_use_imm_o,
  output logic                 ex_zero_ext_o,
  output logic                 ex_branch_o,
  output logic                 redirect_o,
  output logic                 mem_read_o,
  output logic                 mem_write_o,
  output logic                 wb_we_o,
  output logic [RA_W-1:0]      wb_dest_o,
  output logic                 wb_from_mem_o
);

  logic [INSTR_W-1:0] ir_d;
  logic               live_d;
  ctl_word_t          word_d;
  ctl_word_t          word_x;
  ex_ctl_t            ex_ctl;
  logic               redirect;
  logic               ovf_kill;
  logic               mem_wb_pend;

  pdc_fetch_latch u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .live_i   (fetch_valid_i),
    .instr_i  (fetch_instr_i),
    .squash_i (redirect),
    .ir_o     (ir_d),
    .live_o   (live_d)
  );

  pdc_decode u_dec (
    .ir_i   (ir_d),
    .live_i (live_d),
    .word_o (word_d),
    .rs_o   (id_rs_o),
    .rt_o   (id_rt_o)
  );

  pdc_ex_stage u_ex (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_i     (word_d),
    .equal_i    (ex_equal_i),
    .ovf_i      (ex_ovf_i),
    .ex_o       (ex_ctl),
    .vld_o      (ex_valid_o),
    .redirect_o (redirect),
    .ovf_kill_o (ovf_kill),
    .word_o     (word_x)
  );

  pdc_tail u_tail (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_i        (word_x),
    .mem_read_o    (mem_read_o),
    .mem_write_o   (mem_write_o),
    .mem_wb_pend_o (mem_wb_pend),
    .wb_we_o       (wb_we_o),
    .wb_from_mem_o (wb_from_mem_o),
    .wb_dest_o     (wb_dest_o)
  );

  assign id_valid_o    = word_d.vld;
  assign ex_alu_op_o   = ex_ctl.alu;
  assign ex_use_imm_o  = ex_ctl.use_imm;
  assign ex_zero_ext_o = ex_ctl.zero_ext;
  assign ex_branch_o   = ex_ctl.is_branch & ex_valid_o;
  assign redirect_o    = redirect;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wb_we_o && !mem_read_o && !mem_write_o && !ex_valid_o && !id_valid_o));

  a_r5_write_follows_mem: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we_o |-> $past(mem_wb_pend));

  a_r9_shadow_empty: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !id_valid_o);

  a_r10_ovf_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_kill |=> !mem_wb_pend);

endmodule

// File: tb/sim_pdc_ctrl.sv
module sim_pdc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_instr = '0;
  logic        ex_equal = 1'b0;
  logic        ex_ovf = 1'b0;
  logic [4:0]  id_rs, id_rt, wb_dest;
  logic        id_valid, ex_valid, ex_use_imm, ex_zero_ext, ex_branch, redirect;
  logic        mem_read, mem_write, wb_we, wb_from_mem;
  logic [1:0]  ex_alu_op;

  int  n_cmp = 0;
  int  n_bad = 0;
  logic redir_seen;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pdc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid), .fetch_instr_i(fetch_instr),
    .ex_equal_i(ex_equal), .ex_ovf_i(ex_ovf), .id_rs_o(id_rs), .id_rt_o(id_rt),
    .id_valid_o(id_valid), .ex_valid_o(ex_valid), .ex_alu_op_o(ex_alu_op),
    .ex_use_imm_o(ex_use_imm), .ex_zero_ext_o(ex_zero_ext), .ex_branch_o(ex_branch),
    .redirect_o(redirect), .mem_read_o(mem_read), .mem_write_o(mem_write),
    .wb_we_o(wb_we), .wb_dest_o(wb_dest), .wb_from_mem_o(wb_from_mem)
  );

  function automatic logic [31:0] rr(input logic [5:0] fn, input logic [4:0] rd,
                                     input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] im(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, record redirect, cross one rising edge, return at the next falling edge.
  task automatic tick(input logic [31:0] ins, input logic v, input logic eq, input logic ov);
    fetch_instr = ins;
    fetch_valid = v;
    ex_equal    = eq;
    ex_ovf      = ov;
    #1 redir_seen = redirect;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop();
    tick(32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) nop();
  endtask

  task automatic t_reset();
    chk("R1 id_valid in reset", id_valid, 0);
    chk("R1 ex_valid in reset", ex_valid, 0);
    chk("R1 mem strobes in reset", {mem_read, mem_write}, 0);
    chk("R1 wb_we in reset", wb_we, 0);
    chk("R1 redirect in reset", redirect, 0);
  endtask

  task automatic t_reset_midflight();
    tick(rr(6'h20, 5'd3, 5'd1, 5'd2), 1, 0, 0);
    tick(rr(6'h20, 5'd4, 5'd1, 5'd2), 1, 0, 0);
    rst_n = 1'b0;
    nop();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R1 no write after reset", wb_we, 0);
      nop();
    end
  endtask

  task automatic t_rtype();
    flush();
    tick(rr(6'h20, 5'd3, 5'd4, 5'd5), 1, 0, 0);
    chk("R2 rs field", id_rs, 4);
    chk("R2 rt field", id_rt, 5);
    chk("R2 decode valid", id_valid, 1);
    tick(rr(6'h22, 5'd6, 5'd1, 5'd1), 1, 0, 0);
    chk("R3 add in execute", {ex_valid, ex_alu_op, ex_use_imm}, {1'b1, 2'd0, 1'b0});
    tick(rr(6'h24, 5'd7, 5'd1, 5'd1), 1, 0, 0);
    chk("R4 register op passes memory", {mem_read, mem_write}, 0);
    chk("R3 sub in execute", ex_alu_op, 1);
    chk("R5 not written early", wb_we, 0);
    nop();
    chk("R3 and in execute", ex_alu_op, 2);
    chk("R5 add writes in stage 5", wb_we, 1);
    chk("R6 register op uses rd", wb_dest, 3);
    chk("R5 register op not from memory", wb_from_mem, 0);
    nop();
    chk("R6 sub dest", {wb_we, wb_dest}, {1'b1, 5'd6});
  endtask

  task automatic t_load_ori();
    flush();
    tick(im(6'h23, 5'd1, 5'd2, 16'd35), 1, 0, 0);
    tick(im(6'h0D, 5'd8, 5'd9, 16'd17), 1, 0, 0);
    chk("R3 load address add", {ex_alu_op, ex_use_imm, ex_zero_ext}, {2'd0, 1'b1, 1'b0});
    nop();
    chk("R4 load reads memory", mem_read, 1);
    chk("R3 ori controls", {ex_alu_op, ex_use_imm, ex_zero_ext}, {2'd3, 1'b1, 1'b1});
    nop();
    chk("R4 ori passes memory", mem_read, 0);
    chk("R6 load writes rt", {wb_we, wb_dest, wb_from_mem}, {1'b1, 5'd1, 1'b1});
    nop();
    chk("R6 ori writes rt", {wb_we, wb_dest, wb_from_mem}, {1'b1, 5'd8, 1'b0});
  endtask

  task automatic t_store_branch();
    flush();
    tick(im(6'h2B, 5'd6, 5'd7, 16'd4), 1, 0, 0);
    tick(im(6'h04, 5'd7, 5'd6, 16'd64), 1, 0, 0);
    chk("R3 store in execute", {ex_alu_op, ex_use_imm, ex_branch}, {2'd0, 1'b1, 1'b0});
    nop();
    chk("R4 store strobe", {mem_write, mem_read}, {1'b1, 1'b0});
    chk("R3 branch in execute", {ex_branch, ex_alu_op}, {1'b1, 2'd1});
    tick(32'h0, 0, 0, 0);
    chk("R8 untaken branch no redirect", redir_seen, 0);
    chk("R7 store no write", wb_we, 0);
    chk("R7 branch no memory", {mem_read, mem_write}, 0);
    nop();
    chk("R7 branch no write", wb_we, 0);
  endtask

  task automatic t_branch(input logic taken);
    flush();
    tick(im(6'h04, 5'd7, 5'd6, 16'd64), 1, 0, 0);
    tick(rr(6'h20, 5'd10, 5'd11, 5'd12), 1, 0, 0);
    tick(rr(6'h20, 5'd13, 5'd14, 5'd15), 1, taken, 0);
    chk(taken ? "R8 taken branch redirects" : "R8 not-taken no redirect", redir_seen, taken);
    chk("R9 shadow slot in decode", id_valid, !taken);
    nop();
    nop();
    chk("R9 delay slot completes", {wb_we, wb_dest}, {1'b1, 5'd10});
    nop();
    chk(taken ? "R9 shadow squashed" : "R9 untaken shadow completes", wb_we, !taken);
    if (!taken) chk("R9 shadow dest", wb_dest, 13);
  endtask

  task automatic t_equal_no_branch();
    flush();
    tick(rr(6'h20, 5'd20, 5'd1, 5'd1), 1, 0, 0);
    tick(rr(6'h20, 5'd21, 5'd1, 5'd1), 1, 0, 0);
    tick(rr(6'h20, 5'd22, 5'd1, 5'd1), 1, 1, 0);
    chk("R8 equal ignored off branch", redir_seen, 0);
    nop();
    nop();
    nop();
    chk("R8 following instr unaffected", {wb_we, wb_dest}, {1'b1, 5'd22});
  endtask

  task automatic t_overflow();
    flush();
    tick(rr(6'h20, 5'd5, 5'd1, 5'd2), 1, 0, 0);
    tick(im(6'h0D, 5'd6, 5'd1, 16'hFFFF), 1, 0, 0);
    tick(im(6'h08, 5'd7, 5'd1, 16'd9), 1, 0, 1);
    tick(32'h0, 0, 0, 1);
    chk("R10 add overflow cancels", wb_we, 0);
    tick(32'h0, 0, 0, 0);
    chk("R10 ori ignores overflow", {wb_we, wb_dest}, {1'b1, 5'd6});
    nop();
    chk("R10 addi without flag writes", {wb_we, wb_dest}, {1'b1, 5'd7});
    tick(im(6'h08, 5'd9, 5'd1, 16'd1), 1, 0, 0);
    nop();
    tick(32'h0, 0, 0, 1);
    nop();
    chk("R10 addi overflow cancels", wb_we, 0);
    tick(rr(6'h22, 5'd11, 5'd1, 5'd2), 1, 0, 0);
    nop();
    tick(32'h0, 0, 0, 1);
    nop();
    chk("R10 sub overflow cancels", wb_we, 0);
  endtask

  task automatic t_invalid();
    flush();
    tick({6'h3F, 26'h0ABCDEF}, 1, 0, 0);
    chk("R7 unknown opcode not live", id_valid, 0);
    tick(rr(6'h20, 5'd12, 5'd1, 5'd1), 0, 0, 0);
    chk("R7 invalid fetch not live", id_valid, 0);
    tick(rr(6'h3E, 5'd14, 5'd1, 5'd1), 1, 0, 0);
    chk("R7 unknown function not live", id_valid, 0);
    for (int i = 0; i < 3; i++) begin
      nop();
      chk("R7 nothing written", {wb_we, mem_read, mem_write}, 0);
    end
  endtask

  task automatic t_stream();
    logic [31:0] prog [5];
    logic [4:0]  dst  [5];
    logic        isld [5];
    prog[0] = im(6'h23, 5'd1, 5'd2, 16'd0);   dst[0] = 1;  isld[0] = 1;
    prog[1] = rr(6'h25, 5'd2, 5'd3, 5'd4);    dst[1] = 2;  isld[1] = 0;
    prog[2] = im(6'h23, 5'd3, 5'd5, 16'd8);   dst[2] = 3;  isld[2] = 1;
    prog[3] = im(6'h0D, 5'd4, 5'd5, 16'd1);   dst[3] = 4;  isld[3] = 0;
    prog[4] = rr(6'h20, 5'd5, 5'd6, 5'd7);    dst[4] = 5;  isld[4] = 0;
    flush();
    for (int t = 1; t <= 8; t++) begin
      if (t <= 5) tick(prog[t-1], 1, 0, 0);
      else        nop();
      if (t >= 3 && t <= 7) chk("R4 stream memory read", mem_read, isld[t-3]);
      if (t >= 4) chk("R5 stream one writer per cycle", {wb_we, wb_dest, wb_from_mem},
                      {1'b1, dst[t-4], isld[t-4]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rtype();
    t_load_ori();
    t_store_branch();
    t_branch(1'b1);
    t_branch(1'b0);
    t_equal_no_branch();
    t_overflow();
    t_invalid();
    t_stream();
    t_reset_midflight();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule